// File: doc/BRIEF.md
# Interrupt Request Trigger Conditioner

This block prepares fifteen interrupt request sources for a pair of cascaded PC-style interrupt controllers. It synchronizes every source, detects its request according to a per-line trigger mode, and presents one registered pending bit per line. The priority logic downstream reads these bits and acknowledges them through a per-line clear vector. Line 0 is driven by output 0 of the on-chip interval timer rather than by a pin. Line 2 is kept for the cascade link and never reports a request.

Two byte-wide mode inputs choose edge or level detection for each line. In edge mode, most lines react to a rising transition. Lines 8 and 13 react to a falling transition so that they can accept a real-time-clock alarm or a coprocessor error signal directly. The pins have no pull-ups, so a floating input is sampled as whatever value it presents.

Each usable line runs a two-state machine. LN_QUIET means no request. LN_HELD means a request is pending.
- Edge mode: `capture` (a detected edge) moves the line from LN_QUIET to LN_HELD. `retire` (acknowledge with no edge) moves it from LN_HELD to LN_QUIET. Otherwise the line stays in its state.
- Level mode: `track` takes LN_HELD while the line is at its active level and LN_QUIET otherwise.

Top module: `irq_trig_front`

## Requirements
- R1: While reset is asserted and on the first cycle after its release, all 16 bits of `pend` are 0.
- R2: In edge mode, a rising transition on any line other than 0, 2, 8 and 13 sets that line's `pend` bit on the third rising clock edge after the input changes. A falling transition on such a line has no effect.
- R3: In edge mode, lines 8 and 13 set their `pend` bit on a falling transition, with the same latency as R2. A rising transition on these lines has no effect.
- R4: In edge mode, a pending bit stays set until `ack` bit i is 1 at a clock edge. That edge clears the bit. An `ack` bit for a line that is not pending has no effect.
- R5: In edge mode, when a detected edge and `ack` for the same line fall on the same clock edge, the bit ends set.
- R6: In level mode, `pend` bit i equals the line's active level delayed by the same latency as R2, and `ack` has no effect. The active level is high for all lines except 8 and 13, which are active low.
- R7: A mode bit value of 1 selects level mode and 0 selects edge mode. Bit i of `lvl_lo` controls line i (0 to 7), and bit i of `lvl_hi` controls line 8+i. When a line switches from level to edge mode, its pending bit keeps its value.
- R8: Line 0 takes its request from `tmr_out0`, and `irq_ext[0]` has no effect on any output.
- R9: `pend[2]` is always 0, whatever the values of `irq_ext[2]`, `ack[2]` and `lvl_lo[2]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmr_out0 | input | 1 | Interval timer output 0, source of line 0 |
| irq_ext | input | 16 | External request pins; bits 0 and 2 unused |
| lvl_lo | input | 8 | Level-mode selects for lines 0 to 7 |
| lvl_hi | input | 8 | Level-mode selects for lines 8 to 15 |
| ack | input | 16 | Per-line clear of edge-mode pending bits |
| pend | output | 16 | Per-line pending request bits |

## Verification
The block is driven with the following input patterns:
- Single rising pulses on ordinary lines and falling pulses on lines 8 and 13. These show that each line uses the correct edge polarity, and the opposite transition on the same lines shows that no both-edge detector is present.
- Acknowledges with no edge, and acknowledges that coincide with a fresh edge. These separate a sticky pending bit from a pulsed one and confirm that a new edge wins over a clear.
- Level-mode runs with held inputs and with acknowledges during the active level. These show that the bit follows the pin and cannot be cleared.
- Toggling `irq_ext[0]` and line 2's pin, acknowledge and mode bits. These reveal a wrong source mux or a missing tie-off.
- A long random phase compares every bit against the reference model on every clock, to catch interactions between the patterns above.

// File: rtl/irqf_pkg.sv
package irqf_pkg;
    localparam int LINES    = 16;
    localparam int RSV_LINE = 2;
    // lines whose request is active low / falling-edge triggered
    localparam logic [LINES-1:0] ACT_LOW = 16'h2100;

    typedef enum logic {
        LN_QUIET = 1'b0,
        LN_HELD  = 1'b1
    } ln_state_t;
endpackage

// File: rtl/irqf_sync.sv
module irqf_sync #(
    parameter int              N    = 16,
    parameter logic [N-1:0]    IDLE = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw,
    output logic [N-1:0] cur,
    output logic [N-1:0] old
);
    logic [N-1:0] stage1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= IDLE;
            cur    <= IDLE;
            old    <= IDLE;
        end else begin
            stage1 <= raw;
            cur    <= stage1;
            old    <= cur;
        end
    end
endmodule

// File: rtl/irqf_line.sv
module irqf_line
    import irqf_pkg::*;
#(
    parameter bit FALLING = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cur,
    input  logic old,
    input  logic level_mode,
    input  logic clr,
    output logic pending
);
    ln_state_t state_q, state_d;
    logic      active, hit;

    generate
        if (FALLING) begin : g_fall
            assign active = ~cur;
            assign hit    = old & ~cur;
        end else begin : g_rise
            assign active = cur;
            assign hit    = cur & ~old;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LN_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (level_mode) begin
            // track
            state_d = active ? LN_HELD : LN_QUIET;
        end else begin
            unique case (state_q)
                LN_QUIET: if (hit) state_d = LN_HELD;     // capture
                LN_HELD:  if (clr && !hit) state_d = LN_QUIET; // retire
                default:  state_d = LN_QUIET;
            endcase
        end
    end

    assign pending = (state_q == LN_HELD);

    p_edge_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!level_mode && hit) |=> pending);
    p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!level_mode && hit && clr) |=> pending);
    p_ack_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!level_mode && clr && !hit) |=> !pending);
    p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!level_mode && !clr && pending) |=> pending);
    p_level_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        level_mode |=> (pending == $past(active)));
endmodule

// File: rtl/irq_trig_front.sv
module irq_trig_front
    import irqf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tmr_out0,
    input  logic [15:0] irq_ext,
    input  logic [7:0]  lvl_lo,
    input  logic [7:0]  lvl_hi,
    input  logic [15:0] ack,
    output logic [15:0] pend
);
    logic [LINES-1:0] raw, cur, old, lvl;
    logic             unused_bits;

    // line 0 from the timer, reserved line held inactive
    always_comb begin
        raw           = irq_ext;
        raw[0]        = tmr_out0;
        raw[RSV_LINE] = ACT_LOW[RSV_LINE];
    end

    assign lvl = {lvl_hi, lvl_lo};

    irqf_sync #(.N(LINES), .IDLE(ACT_LOW)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   (raw),
        .cur   (cur),
        .old   (old)
    );

    for (genvar i = 0; i < LINES; i++) begin : g_line
        if (i == RSV_LINE) begin : g_rsv
            assign pend[i] = 1'b0;
        end else begin : g_use
            irqf_line #(.FALLING(ACT_LOW[i])) u_line (
                .clk        (clk),
                .rst_n      (rst_n),
                .cur        (cur[i]),
                .old        (old[i]),
                .level_mode (lvl[i]),
                .clr        (ack[i]),
                .pending    (pend[i])
            );
        end
    end

    assign unused_bits = ^{irq_ext[0], irq_ext[RSV_LINE], ack[RSV_LINE],
                           lvl[RSV_LINE], cur[RSV_LINE], old[RSV_LINE]};

    p_line2_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pend[RSV_LINE] == 1'b0);
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (pend == '0));
endmodule

// File: tb/test_irq_trig_front.sv
module test_irq_trig_front;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tmr_out0 = 1'b0;
    logic [15:0] irq_ext = 16'h2100;
    logic [7:0]  lvl_lo = '0;
    logic [7:0]  lvl_hi = '0;
    logic [15:0] ack = '0;
    logic [15:0] pend;

    localparam logic [15:0] LOWACT = 16'h2100;

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cyc   = 0;
    string tag   = "R1";

    logic [15:0] hist[$];
    logic [15:0] m_pend;

    always #10 clk = ~clk;

    irq_trig_front i_irq_trig_front (
        .clk(clk), .rst_n(rst_n), .tmr_out0(tmr_out0), .irq_ext(irq_ext),
        .lvl_lo(lvl_lo), .lvl_hi(lvl_hi), .ack(ack), .pend(pend)
    );

    // reference model: delay line of raw source vectors
    initial begin
        hist   = '{LOWACT, LOWACT, LOWACT};
        m_pend = '0;
    end

    always @(posedge clk) begin
        logic [15:0] rawv, c, o, mode;
        cyc++;
        rawv = irq_ext;
        rawv[0] = tmr_out0;
        if (!rst_n) begin
            hist   = '{LOWACT, LOWACT, LOWACT};
            m_pend = '0;
        end else begin
            c = hist[1];
            o = hist[2];
            mode = {lvl_hi, lvl_lo};
            for (int i = 0; i < 16; i++) begin
                bit act, edg;
                act = LOWACT[i] ? !c[i] : c[i];
                edg = LOWACT[i] ? (o[i] && !c[i]) : (c[i] && !o[i]);
                if (i == 2) m_pend[i] = 1'b0;
                else if (mode[i]) m_pend[i] = act;
                else if (edg) m_pend[i] = 1'b1;
                else if (ack[i]) m_pend[i] = 1'b0;
            end
            hist.push_front(rawv);
            void'(hist.pop_back());
        end
    end

    always @(negedge clk) begin
        n_cmp++;
        if (pend !== m_pend) begin
            n_bad++;
            $display("FAIL %s cycle %0d: pend actual %h expected %h", tag, cyc, pend, m_pend);
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_ack(logic [15:0] v);
        ack = v; tick(1); ack = '0;
    endtask

    initial begin
        tag = "R1";
        tick(3);
        if (pend !== '0) begin
            n_bad++;
            $display("FAIL R1: reset pend actual %h expected 0000", pend);
        end
        n_cmp++;
        rst_n = 1'b1;
        tick(2);
        // R2: rising edges on ordinary lines, then falling (no effect)
        tag = "R2";
        irq_ext = irq_ext | 16'h8092; tick(5);
        irq_ext = irq_ext & ~16'h8092; tick(5);
        // R3: falling edges on 8 and 13, rising ignored
        tag = "R3";
        irq_ext = irq_ext & ~16'h2100; tick(5);
        irq_ext = irq_ext | 16'h2100; tick(5);
        // R4: acknowledge clears, sticky otherwise
        tag = "R4";
        pulse_ack(16'h0080); tick(3);
        pulse_ack(16'hFFFF); tick(3);
        pulse_ack(16'h0400); tick(3);
        // R5: edge coincides with ack
        tag = "R5";
        irq_ext[5] = 1'b1; tick(2);
        pulse_ack(16'h0020); tick(3);
        irq_ext[5] = 1'b0; pulse_ack(16'h0020); tick(2);
        // R6/R7: level mode on line 3 and line 13
        tag = "R6";
        lvl_lo = 8'h08; lvl_hi = 8'h20;
        irq_ext[3] = 1'b1; irq_ext[13] = 1'b0; tick(5);
        pulse_ack(16'h2008); tick(3);
        irq_ext[3] = 1'b0; irq_ext[13] = 1'b1; tick(5);
        tag = "R7";
        irq_ext[3] = 1'b1; tick(5);
        lvl_lo = 8'h00; irq_ext[3] = 1'b0; tick(5);
        pulse_ack(16'h0008); tick(3);
        // R8: line 0 from timer only
        tag = "R8";
        irq_ext[0] = 1'b1; tick(5);
        tmr_out0 = 1'b1; tick(5);
        pulse_ack(16'h0001); irq_ext[0] = 1'b0; tmr_out0 = 1'b0; tick(4);
        // R9: reserved line
        tag = "R9";
        lvl_lo = 8'h04; irq_ext[2] = 1'b1; tick(4);
        lvl_lo = 8'h00; irq_ext[2] = 1'b0; tick(4); irq_ext[2] = 1'b1; tick(4);
        // random mix of all features
        tag = "R2";
        for (int k = 0; k < 3000; k++) begin
            irq_ext  = 16'($urandom);
            tmr_out0 = 1'($urandom);
            ack      = ($urandom % 4 == 0) ? 16'($urandom) : '0;
            if ($urandom % 50 == 0) begin
                lvl_lo = 8'($urandom); lvl_hi = 8'($urandom);
            end
            tick(1 + $urandom % 3);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule